// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by following a two-level page table in memory. A caller presents a virtual address, a write-intent flag and the physical base of the root table. The walker reads the root-level entry and then the leaf-level entry. It reports either the translated address or a page fault, along with the level at which the walk stopped.

Pages are 4 KiB, so the low 12 address bits pass through untranslated. The top 10 bits index the root table. The middle 10 bits index the second-level table that the root entry points to. Each table entry is one 32-bit word:

- Bits [31:12] hold a frame number, or a table number in a root entry.
- Bit 0 is the present flag.
- Bit 1 is the modified flag.

The root table itself is always resident. A root entry with its present flag clear means that the second-level table is absent.

When a write-intent walk reaches a present leaf whose modified flag is clear, the walker writes the entry back with that flag set, using one extra memory write cycle. Only one walk runs at a time. The memory read port takes a one-cycle request and returns data with a valid strobe some cycles later.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: A request with `req_valid` high while `busy` is low is taken at that clock edge. On the next cycle `busy` is high and a read is issued at `root_base + 4*vaddr[31:22]`.
- R3: `req_valid` is ignored while `busy` is high. It issues no read and produces no extra `done`.
- R4: If the root entry has bit 0 clear, the walk ends with `fault`=1, `fault_level`=0 and `paddr`=0, and no second read is issued.
- R5: If the root entry is present, the second read goes to `{root_entry[31:12], 12'h000} + 4*vaddr[21:12]`.
- R6: If the leaf entry has bit 0 clear, the walk ends with `fault`=1, `fault_level`=1 and `paddr`=0.
- R7: If the leaf entry is present, the walk ends with `fault`=0 and `paddr` = `{leaf[31:12], vaddr[11:0]}`.
- R8: For a write-intent walk that reaches a present leaf with bit 1 clear, `mem_wr_req` pulses for exactly one cycle. It writes to the leaf entry address with data equal to the leaf OR 2. `done` follows in the next cycle.
- R9: A read-intent walk, a walk whose leaf already has bit 1 set, and a faulting walk issue no memory write.
- R10: `done` is a one-cycle pulse. `busy` is low in that cycle, so a new request may be taken at the same edge that ends `done`.
- R11: `mem_rd_req` is a one-cycle pulse. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Write intent; marks the leaf as modified |
| root_base | input | 32 | Physical base address of the root table |
| busy | output | 1 | High from acceptance until completion |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Result is a page fault |
| fault_level | output | 1 | 0: root entry absent, 1: leaf entry absent |
| paddr | output | 32 | Translated physical address (0 on fault) |
| mem_rd_req | output | 1 | Memory read request pulse |
| mem_rd_addr | output | 32 | Memory read word address |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Read data (table entry) |
| mem_wr_req | output | 1 | Memory write pulse (entry write-back) |
| mem_wr_addr | output | 32 | Memory write address |
| mem_wr_data | output | 32 | Memory write data |

## Verification
A walk can complete in the same cycle that the next request is taken. `done` rises with `busy` low, and a request already waiting on `req_valid` is accepted at the edge that ends the pulse.

The bench provokes this by calling the driver back to back, so each new request is held high across the previous walk's completion. The mix includes a write-back walk, a root fault and a plain translation. The scoreboard judges both sides independently:

- The finished walk's result must pop from the result queue with `busy` low.
- The following cycle's read must match the next expected root-entry address.
- The leaf write-back must have occurred in the cycle just before `done`.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Flag positions inside a table entry
  localparam int ENTRY_PRESENT  = 0;
  localparam int ENTRY_MODIFIED = 1;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ROOT = 2'd1,
    S_LEAF = 2'd2,
    S_MARK = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int AW      = 32,
  parameter int IW      = 10,
  parameter int EB_LOG2 = 2
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);
  localparam int PAD = AW - IW - EB_LOG2;

  // Entry address = table base + entry size * index
  always_comb addr = base + {{PAD{1'b0}}, idx, {EB_LOG2{1'b0}}};
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int EW    = 32,
  parameter int OFF_W = 12
) (
  input  logic [EW-1:0]       entry,
  output logic [EW-OFF_W-1:0] frame,
  output logic                present,
  output logic                modified,
  output logic [EW-1:0]       marked
);
  import ptw_pkg::*;

  always_comb begin
    frame    = entry[EW-1:OFF_W];
    present  = entry[ENTRY_PRESENT];
    modified = entry[ENTRY_MODIFIED];
    marked   = entry;
    marked[ENTRY_MODIFIED] = 1'b1;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic [PA_W-1:0] root_base,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic            fault_level,
  output logic [PA_W-1:0] paddr,
  output logic            mem_rd_req,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [PA_W-1:0] mem_rd_data,
  output logic            mem_wr_req,
  output logic [PA_W-1:0] mem_wr_addr,
  output logic [PA_W-1:0] mem_wr_data
);
  import ptw_pkg::*;

  localparam int FRAME_W = PA_W - OFF_W;
  localparam int EB_LOG2 = $clog2(PA_W / 8);
  localparam int ROOT_LO = OFF_W + IDX_W;

  walk_state_e         state;
  logic [VA_W-1:0]     va_q;
  logic                wr_q;

  logic [PA_W-1:0]     root_addr_c;
  logic [PA_W-1:0]     leaf_addr_c;
  logic [FRAME_W-1:0]  rd_frame;
  logic                rd_present;
  logic                rd_modified;
  logic [PA_W-1:0]     rd_marked;

  ptw_entry_decode #(.EW(PA_W), .OFF_W(OFF_W)) u_decode (
    .entry    (mem_rd_data),
    .frame    (rd_frame),
    .present  (rd_present),
    .modified (rd_modified),
    .marked   (rd_marked)
  );

  ptw_entry_addr #(.AW(PA_W), .IW(IDX_W), .EB_LOG2(EB_LOG2)) u_root_addr (
    .base (root_base),
    .idx  (req_vaddr[VA_W-1:ROOT_LO]),
    .addr (root_addr_c)
  );

  ptw_entry_addr #(.AW(PA_W), .IW(IDX_W), .EB_LOG2(EB_LOG2)) u_leaf_addr (
    .base ({rd_frame, {OFF_W{1'b0}}}),
    .idx  (va_q[ROOT_LO-1:OFF_W]),
    .addr (leaf_addr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      paddr       <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_req  <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      done       <= 1'b0;
      mem_rd_req <= 1'b0;
      mem_wr_req <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          va_q        <= req_vaddr;
          wr_q        <= req_write;
          busy        <= 1'b1;
          mem_rd_req  <= 1'b1;
          mem_rd_addr <= root_addr_c;
          state       <= S_ROOT;
        end
        S_ROOT: if (mem_rd_valid) begin
          if (!rd_present) begin
            fault       <= 1'b1;
            fault_level <= 1'b0;
            paddr       <= '0;
            done        <= 1'b1;
            busy        <= 1'b0;
            state       <= S_IDLE;
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= leaf_addr_c;
            state       <= S_LEAF;
          end
        end
        S_LEAF: if (mem_rd_valid) begin
          if (!rd_present) begin
            fault       <= 1'b1;
            fault_level <= 1'b1;
            paddr       <= '0;
            done        <= 1'b1;
            busy        <= 1'b0;
            state       <= S_IDLE;
          end else begin
            fault       <= 1'b0;
            fault_level <= 1'b0;
            paddr       <= {rd_frame, va_q[OFF_W-1:0]};
            if (wr_q && !rd_modified) begin
              mem_wr_req  <= 1'b1;
              mem_wr_addr <= mem_rd_addr;
              mem_wr_data <= rd_marked;
              state       <= S_MARK;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        S_MARK: begin
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Acceptance starts a walk with a root read
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> (busy && mem_rd_req));

  // Reads are single-cycle pulses
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // No new read may start while one is pending
  p_rd_single_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && busy) |=> !(mem_rd_req && !$past(mem_rd_valid)));

  // Faulting results carry a zero address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == '0));

  // Offset passes through on a good translation
  p_offset_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // Write-back carries the modified flag and is followed by a clean done
  p_mark_data_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |-> mem_wr_data[ENTRY_MODIFIED]);
  p_mark_done_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_req |=> (done && !fault && !mem_wr_req));

  // done is a pulse with busy already released
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_done_once_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] root_base = '0;
  logic        busy, done, fault, fault_level;
  logic [31:0] paddr;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .root_base(root_base), .busy(busy), .done(done),
    .fault(fault), .fault_level(fault_level), .paddr(paddr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model
  logic [31:0] mem [logic [31:0]];
  int          lat = 2;
  bit          pend = 0;
  int          cnt = 0;
  logic [31:0] maddr = '0;

  function automatic logic [31:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      pend  = 1;
      cnt   = lat;
      maddr = mem_rd_addr;
    end else if (pend) begin
      if (cnt <= 1) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= rdm(maddr);
        pend = 0;
      end else cnt--;
    end
    if (mem_wr_req) mem[mem_wr_addr] = mem_wr_data;
  end

  // Scoreboard queues
  typedef struct {
    logic        flt;
    logic        lvl;
    logic [31:0] pa;
    logic        wr;
  } res_t;
  res_t        res_q[$];
  logic [31:0] rd_q[$];
  logic [63:0] wr_q[$];

  // Monitor
  logic wr_prev = 1'b0;
  logic rd_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_req) begin
        check(!rd_prev, "R11", "read request longer than one cycle", 1, 0);
        if (rd_q.size() == 0)
          check(0, "R3", "unexpected read", {32'h0, mem_rd_addr}, 0);
        else begin
          logic [31:0] ea;
          ea = rd_q.pop_front();
          check(mem_rd_addr == ea, "R2/R5", "read address", {32'h0, mem_rd_addr}, {32'h0, ea});
        end
      end
      if (mem_wr_req) begin
        if (wr_q.size() == 0)
          check(0, "R9", "unexpected write", {mem_wr_addr, mem_wr_data}, 0);
        else begin
          logic [63:0] ew;
          ew = wr_q.pop_front();
          check({mem_wr_addr, mem_wr_data} == ew, "R8", "write addr/data",
                {mem_wr_addr, mem_wr_data}, ew);
        end
      end
      if (done) begin
        check(!busy, "R10", "busy during done", {63'h0, busy}, 0);
        if (res_q.size() == 0)
          check(0, "R3", "unexpected done", 1, 0);
        else begin
          res_t r;
          r = res_q.pop_front();
          check(fault == r.flt, r.flt ? "R4/R6" : "R7", "fault flag", {63'h0, fault}, {63'h0, r.flt});
          if (r.flt)
            check(fault_level == r.lvl, r.lvl ? "R6" : "R4", "fault level",
                  {63'h0, fault_level}, {63'h0, r.lvl});
          check(paddr == r.pa, r.flt ? "R4/R6" : "R7", "physical address",
                {32'h0, paddr}, {32'h0, r.pa});
          check(wr_prev == r.wr, r.wr ? "R8" : "R9", "write cycle before done",
                {63'h0, wr_prev}, {63'h0, r.wr});
        end
      end
      wr_prev = mem_wr_req;
      rd_prev = mem_rd_req;
    end
  end

  localparam logic [31:0] ROOT = 32'h0001_0000;

  // Driver: predicts from the memory contents, then presents the request
  task automatic walk(input logic [31:0] va, input logic wr);
    logic [31:0] a1, a2, e1, e2;
    res_t r;
    a1 = ROOT + {20'h0, va[31:22], 2'b00};
    e1 = rdm(a1);
    rd_q.push_back(a1);
    r.wr = 0; r.lvl = 0; r.pa = '0;
    if (!e1[0]) r.flt = 1;
    else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rdm(a2);
      rd_q.push_back(a2);
      if (!e2[0]) begin r.flt = 1; r.lvl = 1; end
      else begin
        r.flt = 0;
        r.pa  = {e2[31:12], va[11:0]};
        if (wr && !e2[1]) begin
          r.wr = 1;
          wr_q.push_back({a2, e2 | 32'h2});
        end
      end
    end
    res_q.push_back(r);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; root_base = ROOT;
    while (busy) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || res_q.size() != 0);
    @(negedge clk);
  endtask

  localparam logic [31:0] VA_A    = 32'h00C0_5ABC; // idx 3 / 5
  localparam logic [31:0] VA_TOP  = 32'hFFFF_FFFF; // idx 3FF / 3FF
  localparam logic [31:0] VA_RMIS = 32'h01C0_0123; // idx 7: root absent
  localparam logic [31:0] VA_LMIS = 32'h00C0_9010; // idx 3 / 9: leaf absent
  localparam logic [31:0] VA_ZERO = 32'h00C0_0000; // idx 3 / 0

  initial begin
    mem[ROOT + 32'd12]      = 32'h0002_0001;
    mem[ROOT + 32'hFFC]     = 32'h0003_0001;
    mem[32'h0002_0014]      = 32'h1234_5001;
    mem[32'h0002_0000]      = 32'h00AB_C001;
    mem[32'h0003_0FFC]      = 32'hFEDC_B003;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({busy, done, mem_rd_req, mem_wr_req} == 4'b0, "R1", "outputs after reset",
          {60'h0, busy, done, mem_rd_req, mem_wr_req}, 0);

    lat = 1;
    walk(VA_A, 1'b0);            // R2 R5 R7 R9
    wait_idle();

    lat = 3;
    walk(VA_A, 1'b1);            // R8 write-back
    wait_idle();
    check(rdm(32'h0002_0014) == 32'h1234_5003, "R8", "leaf marked in memory",
          {32'h0, rdm(32'h0002_0014)}, {32'h0, 32'h1234_5003});

    walk(VA_A, 1'b1);            // R9 already modified
    wait_idle();
    walk(VA_RMIS, 1'b0);         // R4 root absent
    wait_idle();
    walk(VA_LMIS, 1'b1);         // R6 leaf absent, no write
    wait_idle();

    // R3: requests while busy are ignored
    lat = 6;
    walk(VA_TOP, 1'b0);
    req_valid = 1'b1; req_vaddr = VA_ZERO; req_write = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    check(rdm(32'h0002_0000) == 32'h00AB_C001, "R3", "ignored request left entry",
          {32'h0, rdm(32'h0002_0000)}, {32'h0, 32'h00AB_C001});

    // R10: back-to-back, each taken at the edge that ends done
    lat = 2;
    walk(VA_TOP, 1'b1);
    walk(VA_ZERO, 1'b1);
    walk(VA_RMIS, 1'b0);
    walk(VA_A, 1'b0);
    wait_idle();
    check(rdm(32'h0002_0000) == 32'h00AB_C003, "R8", "second leaf marked",
          {32'h0, rdm(32'h0002_0000)}, {32'h0, 32'h00AB_C003});
    check(rd_q.size() == 0 && wr_q.size() == 0, "R11", "leftover expected accesses",
          {32'h0, rd_q.size()}, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule